// File: doc/BRIEF.md
# Predicated Three-Slot Integer Execute Stage

This block is the execute stage of a wide-issue integer core that accepts one bundle per clock. A bundle holds three instruction slots. Each slot names a guard predicate from a small one-bit predicate file. When the guard reads 1 the slot runs and updates state. When it reads 0 the slot turns into a no-operation. Branches are never involved: a control decision becomes a data decision on the guard bit.

Two operation classes are available in every slot. The add class writes the general register file, either as register plus register or as register plus a sign-extended immediate. The compare class tests two registers for equality or inequality and writes a pair of predicates in one step: the outcome into one and its complement into the other. All three slots read operands and guards from the state that existed before the bundle, and their writes land together at the clock edge that accepts the bundle. A registered commit strobe per slot reports which adds took effect, so that an external model can follow the architectural state.

Top module: `pex_exec_stage`

## Requirements
- R1: During and immediately after reset, every general register reads 0, the predicate vector reads 8'h01 (only predicate 0 set), and all commit strobes are 0.
- R2: Opcode 3 (compare-equal) in an enabled slot writes (rs1 == rs2) into predicate pd1 and the inverse into predicate pd2 at the accepting edge.
- R3: Opcode 4 (compare-not-equal) in an enabled slot writes (rs1 != rs2) into pd1 and the inverse into pd2.
- R4: A slot whose guard predicate reads 0 changes no register and no predicate, and raises no commit strobe.
- R5: Predicate 0 always reads 1. A compare that targets it leaves it at 1, and a slot guarded by predicate 0 behaves as unguarded.
- R6: Opcode 1 writes rs1 + rs2 into rd. Opcode 2 writes rs1 + imm into rd, with the 16-bit imm sign-extended and the sum wrapping modulo 2^32. Opcodes 0 and 5 to 7 do nothing.
- R7: All three slots execute in the same cycle, and each reads register operands as they were before the bundle (no forwarding inside a bundle).
- R8: A predicate written by a bundle is seen by guards of the next bundle. Guards in the same bundle see the old value.
- R9: When enabled adds in several slots target one register, the highest-numbered slot's result remains. A disabled slot takes no part in the conflict.
- R10: When enabled compares write the same predicate, the highest-numbered slot wins. Inside one compare with pd1 == pd2, the complement (pd2) value remains.
- R11: One cycle after the accepting edge, commit strobe bit s is 1 exactly when slot s was an enabled add. Alongside it, slot s's commit register field (bits 4s+3:4s) and data field (bits 32s+31:32s) carry its rd and result.
- R12: With the bundle-valid input at 0, no register, predicate or commit strobe changes, whatever the slot fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_valid_i | input | 1 | Bundle present this cycle |
| slot_op_i | input | 9 | Opcode per slot, slot s at bits 3s+2:3s |
| slot_guard_i | input | 9 | Guard predicate index per slot |
| slot_rd_i | input | 12 | Destination register per slot |
| slot_rs1_i | input | 12 | First source register per slot |
| slot_rs2_i | input | 12 | Second source register per slot |
| slot_imm_i | input | 48 | 16-bit signed immediate per slot |
| slot_pd1_i | input | 9 | Compare result predicate per slot |
| slot_pd2_i | input | 9 | Compare complement predicate per slot |
| peek_addr_i | input | 4 | Register observation address |
| peek_data_o | output | 32 | Current content of the observed register |
| pred_o | output | 8 | Current predicate vector |
| commit_o | output | 3 | Registered per-slot add commit strobes |
| commit_rd_o | output | 12 | Registered destination per slot |
| commit_data_o | output | 96 | Registered result per slot |

## Verification
A wrong guard read or a stale predicate shows up at the first edge after the bundle: a commit strobe goes wrong and the destination register on the peek port takes the wrong value. A wrong compare result or complement shows on the predicate vector at that same edge. A bad write priority or intra-bundle forwarding leaves one register holding the wrong slot's sum, which stays visible on the peek port until something rewrites it. A bad guard value also spreads: the next bundle's guarded adds then commit, or fail to commit, and the strobes diverge within one more cycle.

// File: rtl/pex_pkg.sv
package pex_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ADD_RR = 3'd1,
    OP_ADD_RI = 3'd2,
    OP_CMP_EQ = 3'd3,
    OP_CMP_NE = 3'd4
  } pex_op_e;

  function automatic logic op_is_add(input logic [2:0] op);
    return (op == OP_ADD_RR) || (op == OP_ADD_RI);
  endfunction

  function automatic logic op_is_cmp(input logic [2:0] op);
    return (op == OP_CMP_EQ) || (op == OP_CMP_NE);
  endfunction

endpackage

// File: rtl/pex_slot_alu.sv
module pex_slot_alu
  import pex_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [2:0]        op_i,
  input  logic              issue_i,
  input  logic              guard_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              add_we_o,
  output logic [DATA_W-1:0] add_res_o,
  output logic              cmp_we_o,
  output logic              cmp_res_o
);

  function automatic logic [DATA_W-1:0] widen_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sum(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic cmp_outcome(input logic [2:0] op,
                                       input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b);
    return (a == b) ^ (op == OP_CMP_NE);
  endfunction

  logic enabled;
  logic [DATA_W-1:0] operand_b;

  assign enabled   = issue_i && guard_i;
  assign operand_b = (op_i == OP_ADD_RI) ? widen_imm(imm_i) : src_b_i;
  assign add_we_o  = enabled && op_is_add(op_i);
  assign add_res_o = wrap_sum(src_a_i, operand_b);
  assign cmp_we_o  = enabled && op_is_cmp(op_i);
  assign cmp_res_o = cmp_outcome(op_i, src_a_i, src_b_i);

endmodule

// File: rtl/pex_reg_file.sv
module pex_reg_file #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 16,
  parameter int NUM_SLOTS = 3,
  parameter int NUM_RD    = 2 * NUM_SLOTS,
  localparam int RA_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   raddr_i [NUM_RD],
  output logic [DATA_W-1:0] rdata_o [NUM_RD],
  input  logic              we_i    [NUM_SLOTS],
  input  logic [RA_W-1:0]   waddr_i [NUM_SLOTS],
  input  logic [DATA_W-1:0] wdata_i [NUM_SLOTS],
  input  logic [RA_W-1:0]   peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o
);

  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic [NUM_REGS-1:0] row_hit;

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
  assign peek_data_o = mem_q[peek_addr_i];

  always_comb begin
    row_hit = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (we_i[s]) row_hit[waddr_i[s]] = 1'b1;
  end

  // Later slots are written later in the loop, so they win a conflict.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (we_i[s]) mem_q[waddr_i[s]] <= wdata_i[s];
    end
  end

  for (genvar j = 0; j < NUM_REGS; j++) begin : g_hold
    assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !row_hit[j] |=> $stable(mem_q[j]));
  end

  assert_top_slot_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i[NUM_SLOTS-1] |=> mem_q[$past(waddr_i[NUM_SLOTS-1])] == $past(wdata_i[NUM_SLOTS-1]));

endmodule

// File: rtl/pex_pred_file.sv
module pex_pred_file #(
  parameter int NUM_PREDS = 8,
  parameter int NUM_SLOTS = 3,
  localparam int PA_W     = $clog2(NUM_PREDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_we_i  [NUM_SLOTS],
  input  logic                 cmp_res_i [NUM_SLOTS],
  input  logic [PA_W-1:0]      pd1_i     [NUM_SLOTS],
  input  logic [PA_W-1:0]      pd2_i     [NUM_SLOTS],
  output logic [NUM_PREDS-1:0] pred_o
);

  logic [NUM_PREDS-1:0] pred_q;
  logic any_cmp;

  always_comb begin
    any_cmp = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) any_cmp = any_cmp | cmp_we_i[s];
  end

  // Order of writes: slot 0 first, pd1 before pd2, so the last one remains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= NUM_PREDS'(1);
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cmp_we_i[s]) begin
          if (pd1_i[s] != '0) pred_q[pd1_i[s]] <= cmp_res_i[s];
          if (pd2_i[s] != '0) pred_q[pd2_i[s]] <= ~cmp_res_i[s];
        end
      end
    end
  end

  assign pred_o = pred_q;

  assert_pred_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmp |=> $stable(pred_q));

  assert_pair_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i[NUM_SLOTS-1] && pd1_i[NUM_SLOTS-1] != pd2_i[NUM_SLOTS-1]
     && pd1_i[NUM_SLOTS-1] != '0 && pd2_i[NUM_SLOTS-1] != '0)
    |=> pred_q[$past(pd1_i[NUM_SLOTS-1])] != pred_q[$past(pd2_i[NUM_SLOTS-1])]);

  assert_guard_zero_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_o[0] |=> pred_o[0]);

endmodule

// File: rtl/pex_exec_stage.sv
module pex_exec_stage
  import pex_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int NUM_REGS  = 16,
  parameter int NUM_PREDS = 8,
  parameter int NUM_SLOTS = 3,
  localparam int RA_W     = $clog2(NUM_REGS),
  localparam int PA_W     = $clog2(NUM_PREDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bundle_valid_i,
  input  logic [3*NUM_SLOTS-1:0]      slot_op_i,
  input  logic [PA_W*NUM_SLOTS-1:0]   slot_guard_i,
  input  logic [RA_W*NUM_SLOTS-1:0]   slot_rd_i,
  input  logic [RA_W*NUM_SLOTS-1:0]   slot_rs1_i,
  input  logic [RA_W*NUM_SLOTS-1:0]   slot_rs2_i,
  input  logic [IMM_W*NUM_SLOTS-1:0]  slot_imm_i,
  input  logic [PA_W*NUM_SLOTS-1:0]   slot_pd1_i,
  input  logic [PA_W*NUM_SLOTS-1:0]   slot_pd2_i,
  input  logic [RA_W-1:0]             peek_addr_i,
  output logic [DATA_W-1:0]           peek_data_o,
  output logic [NUM_PREDS-1:0]        pred_o,
  output logic [NUM_SLOTS-1:0]        commit_o,
  output logic [RA_W*NUM_SLOTS-1:0]   commit_rd_o,
  output logic [DATA_W*NUM_SLOTS-1:0] commit_data_o
);

  localparam int NUM_RD = 2 * NUM_SLOTS;

  logic [RA_W-1:0]   rf_raddr [NUM_RD];
  logic [DATA_W-1:0] rf_rdata [NUM_RD];
  logic              add_we   [NUM_SLOTS];
  logic [RA_W-1:0]   add_rd   [NUM_SLOTS];
  logic [DATA_W-1:0] add_res  [NUM_SLOTS];
  logic              cmp_we   [NUM_SLOTS];
  logic              cmp_res  [NUM_SLOTS];
  logic [PA_W-1:0]   cmp_pd1  [NUM_SLOTS];
  logic [PA_W-1:0]   cmp_pd2  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_guard_bit;
  logic [NUM_PREDS-1:0] pred_vec;

  logic [NUM_SLOTS-1:0]        commit_q;
  logic [RA_W*NUM_SLOTS-1:0]   commit_rd_q;
  logic [DATA_W*NUM_SLOTS-1:0] commit_data_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign rf_raddr[2*s]   = slot_rs1_i[RA_W*s +: RA_W];
    assign rf_raddr[2*s+1] = slot_rs2_i[RA_W*s +: RA_W];
    assign add_rd[s]       = slot_rd_i[RA_W*s +: RA_W];
    assign cmp_pd1[s]      = slot_pd1_i[PA_W*s +: PA_W];
    assign cmp_pd2[s]      = slot_pd2_i[PA_W*s +: PA_W];
    assign slot_guard_bit[s] = pred_vec[slot_guard_i[PA_W*s +: PA_W]];

    pex_slot_alu #(
      .DATA_W(DATA_W),
      .IMM_W (IMM_W)
    ) i_alu (
      .op_i     (slot_op_i[3*s +: 3]),
      .issue_i  (bundle_valid_i),
      .guard_i  (slot_guard_bit[s]),
      .src_a_i  (rf_rdata[2*s]),
      .src_b_i  (rf_rdata[2*s+1]),
      .imm_i    (slot_imm_i[IMM_W*s +: IMM_W]),
      .add_we_o (add_we[s]),
      .add_res_o(add_res[s]),
      .cmp_we_o (cmp_we[s]),
      .cmp_res_o(cmp_res[s])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        commit_q[s]                     <= 1'b0;
        commit_rd_q[RA_W*s +: RA_W]     <= '0;
        commit_data_q[DATA_W*s +: DATA_W] <= '0;
      end else begin
        commit_q[s]                     <= add_we[s];
        commit_rd_q[RA_W*s +: RA_W]     <= add_rd[s];
        commit_data_q[DATA_W*s +: DATA_W] <= add_res[s];
      end
    end

    assert_commit_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o[s] |-> $past(bundle_valid_i && slot_guard_bit[s]));

    assert_commit_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bundle_valid_i |=> !commit_o[s]);
  end

  pex_reg_file #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .NUM_SLOTS(NUM_SLOTS),
    .NUM_RD   (NUM_RD)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .raddr_i    (rf_raddr),
    .rdata_o    (rf_rdata),
    .we_i       (add_we),
    .waddr_i    (add_rd),
    .wdata_i    (add_res),
    .peek_addr_i(peek_addr_i),
    .peek_data_o(peek_data_o)
  );

  pex_pred_file #(
    .NUM_PREDS(NUM_PREDS),
    .NUM_SLOTS(NUM_SLOTS)
  ) i_preds (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_we_i (cmp_we),
    .cmp_res_i(cmp_res),
    .pd1_i    (cmp_pd1),
    .pd2_i    (cmp_pd2),
    .pred_o   (pred_vec)
  );

  assign pred_o        = pred_vec;
  assign commit_o      = commit_q;
  assign commit_rd_o   = commit_rd_q;
  assign commit_data_o = commit_data_q;

endmodule

// File: tb/test_pex_exec_stage.sv
`timescale 1ns/10ps
module test_pex_exec_stage;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  guard;
    logic [3:0]  rd;
    logic [3:0]  rs1;
    logic [3:0]  rs2;
    logic [15:0] imm;
    logic [2:0]  pd1;
    logic [2:0]  pd2;
  } slot_t;

  localparam int NB = 11;
  // fields: {op, guard, rd, rs1, rs2, imm, pd1, pd2}; index = bundle*3 + slot
  localparam slot_t VEC [3*NB] = '{
    // b0 R6: three immediate adds in parallel
    {3'd2,3'd0,4'd1,4'd0,4'd0,16'd5,3'd0,3'd0},
    {3'd2,3'd0,4'd2,4'd0,4'd0,16'd5,3'd0,3'd0},
    {3'd2,3'd0,4'd3,4'd0,4'd0,16'd7,3'd0,3'd0},
    // b1 R2 R3 R8: compares, guarded add on still-zero p1
    {3'd3,3'd0,4'd0,4'd1,4'd2,16'd0,3'd1,3'd2},
    {3'd4,3'd0,4'd0,4'd1,4'd3,16'd0,3'd3,3'd4},
    {3'd2,3'd1,4'd4,4'd0,4'd0,16'd1,3'd0,3'd0},
    // b2 R4 R6: reg+reg on p1, false p2, true p3
    {3'd1,3'd1,4'd4,4'd1,4'd3,16'd0,3'd0,3'd0},
    {3'd2,3'd2,4'd5,4'd5,4'd0,16'd1,3'd0,3'd0},
    {3'd2,3'd3,4'd6,4'd6,4'd0,16'd1,3'd0,3'd0},
    // b3 R9: conflict on r7, slot 2 disabled
    {3'd2,3'd0,4'd7,4'd0,4'd0,16'd10,3'd0,3'd0},
    {3'd2,3'd0,4'd7,4'd0,4'd0,16'd20,3'd0,3'd0},
    {3'd2,3'd2,4'd7,4'd0,4'd0,16'd30,3'd0,3'd0},
    // b4 R7: no forwarding inside a bundle
    {3'd2,3'd0,4'd1,4'd1,4'd0,16'd1,3'd0,3'd0},
    {3'd1,3'd0,4'd8,4'd1,4'd0,16'd0,3'd0,3'd0},
    40'd0,
    // b5 R5: compare targets p0
    {3'd3,3'd0,4'd0,4'd1,4'd2,16'd0,3'd0,3'd5},
    40'd0,
    40'd0,
    // b6 R10: pd1 == pd2, complement remains
    {3'd3,3'd0,4'd0,4'd0,4'd0,16'd0,3'd6,3'd6},
    40'd0,
    {3'd5,3'd0,4'd9,4'd0,4'd0,16'd9,3'd0,3'd0},
    // b7 R10: two compares on p7, slot 2 wins
    {3'd3,3'd0,4'd0,4'd0,4'd0,16'd0,3'd7,3'd1},
    40'd0,
    {3'd4,3'd0,4'd0,4'd0,4'd0,16'd0,3'd7,3'd2},
    // b8 R6: negative immediate wraps
    {3'd2,3'd0,4'd9,4'd3,4'd0,16'hFFFF,3'd0,3'd0},
    {3'd2,3'd0,4'd10,4'd0,4'd0,16'h8000,3'd0,3'd0},
    40'd0,
    // b9 R12: valid low, busy fields
    {3'd2,3'd0,4'd11,4'd0,4'd0,16'd77,3'd0,3'd0},
    {3'd3,3'd0,4'd0,4'd0,4'd0,16'd0,3'd3,3'd4},
    {3'd1,3'd0,4'd1,4'd1,4'd1,16'd0,3'd0,3'd0},
    // b10 R8: same-bundle guard reads the old p3/p4
    {3'd4,3'd0,4'd0,4'd0,4'd0,16'd0,3'd3,3'd4},
    {3'd2,3'd3,4'd12,4'd0,4'd0,16'd3,3'd0,3'd0},
    {3'd2,3'd4,4'd13,4'd0,4'd0,16'd4,3'd0,3'd0}
  };
  localparam logic [NB-1:0] VALID = 11'b101_1111_1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bundle_valid_i = 1'b0;
  logic [8:0]  slot_op_i = '0, slot_guard_i = '0, slot_pd1_i = '0, slot_pd2_i = '0;
  logic [11:0] slot_rd_i = '0, slot_rs1_i = '0, slot_rs2_i = '0;
  logic [47:0] slot_imm_i = '0;
  logic [3:0]  peek_addr_i = '0;
  logic [31:0] peek_data_o;
  logic [7:0]  pred_o;
  logic [2:0]  commit_o;
  logic [11:0] commit_rd_o;
  logic [95:0] commit_data_o;

  always #5 clk = ~clk;

  pex_exec_stage i_pex_exec_stage (
    .clk(clk), .rst_n(rst_n), .bundle_valid_i(bundle_valid_i),
    .slot_op_i(slot_op_i), .slot_guard_i(slot_guard_i), .slot_rd_i(slot_rd_i),
    .slot_rs1_i(slot_rs1_i), .slot_rs2_i(slot_rs2_i), .slot_imm_i(slot_imm_i),
    .slot_pd1_i(slot_pd1_i), .slot_pd2_i(slot_pd2_i), .peek_addr_i(peek_addr_i),
    .peek_data_o(peek_data_o), .pred_o(pred_o), .commit_o(commit_o),
    .commit_rd_o(commit_rd_o), .commit_data_o(commit_data_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] m_reg [16];
  logic [7:0]  m_pred;
  logic [2:0]  m_commit;
  logic [3:0]  m_crd  [3];
  logic [31:0] m_cdat [3];

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_pred = 8'h01;
    m_commit = '0;
  endtask

  // Reference: read old state, apply slots in order so later slots overwrite.
  task automatic model_step(input logic v, input slot_t s0, input slot_t s1, input slot_t s2);
    slot_t sl [3];
    logic [31:0] old_r [16];
    logic [7:0] old_p;
    logic outcome;
    logic [31:0] b;
    sl[0] = s0; sl[1] = s1; sl[2] = s2;
    for (int i = 0; i < 16; i++) old_r[i] = m_reg[i];
    old_p = m_pred;
    m_commit = '0;
    for (int s = 0; s < 3; s++) begin
      if (v && old_p[sl[s].guard]) begin
        if (sl[s].op == 3'd1 || sl[s].op == 3'd2) begin
          b = (sl[s].op == 3'd1) ? old_r[sl[s].rs2] : {{16{sl[s].imm[15]}}, sl[s].imm};
          m_reg[sl[s].rd] = old_r[sl[s].rs1] + b;
          m_commit[s] = 1'b1;
          m_crd[s] = sl[s].rd;
          m_cdat[s] = old_r[sl[s].rs1] + b;
        end else if (sl[s].op == 3'd3 || sl[s].op == 3'd4) begin
          outcome = (old_r[sl[s].rs1] == old_r[sl[s].rs2]);
          if (sl[s].op == 3'd4) outcome = !outcome;
          m_pred[sl[s].pd1] = outcome;
          m_pred[sl[s].pd2] = !outcome;
          m_pred[0] = 1'b1;
        end
      end
    end
  endtask

  task automatic drive(input logic v, input slot_t s0, input slot_t s1, input slot_t s2);
    slot_t sl [3];
    sl[0] = s0; sl[1] = s1; sl[2] = s2;
    bundle_valid_i = v;
    for (int s = 0; s < 3; s++) begin
      slot_op_i[3*s +: 3]     = sl[s].op;
      slot_guard_i[3*s +: 3]  = sl[s].guard;
      slot_rd_i[4*s +: 4]     = sl[s].rd;
      slot_rs1_i[4*s +: 4]    = sl[s].rs1;
      slot_rs2_i[4*s +: 4]    = sl[s].rs2;
      slot_imm_i[16*s +: 16]  = sl[s].imm;
      slot_pd1_i[3*s +: 3]    = sl[s].pd1;
      slot_pd2_i[3*s +: 3]    = sl[s].pd2;
    end
  endtask

  task automatic check_state(input string req);
    for (int r = 0; r < 16; r++) begin
      peek_addr_i = 4'(r);
      #0.2;
      check(peek_data_o == m_reg[r], req, $sformatf("reg r%0d", r), peek_data_o, m_reg[r]);
    end
    check(pred_o == m_pred, req, "predicates", {24'd0, pred_o}, {24'd0, m_pred});
    check(commit_o == m_commit, req, "commit strobes R11", {29'd0, commit_o}, {29'd0, m_commit});
    for (int s = 0; s < 3; s++) begin
      if (m_commit[s] && commit_o[s]) begin
        check(commit_rd_o[4*s +: 4] == m_crd[s], req, "commit rd R11",
              {28'd0, commit_rd_o[4*s +: 4]}, {28'd0, m_crd[s]});
        check(commit_data_o[32*s +: 32] == m_cdat[s], req, "commit data R11",
              commit_data_o[32*s +: 32], m_cdat[s]);
      end
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    string tags [NB] = '{"R6 R7", "R2 R3 R8", "R4 R6", "R9", "R7",
                         "R5", "R10", "R10", "R6", "R12", "R8"};
    model_reset();
    drive(1'b0, '0, '0, '0);
    #12;
    check_state("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after reset");

    for (int b = 0; b < NB; b++) begin
      drive(VALID[b], VEC[3*b], VEC[3*b+1], VEC[3*b+2]);
      model_step(VALID[b], VEC[3*b], VEC[3*b+1], VEC[3*b+2]);
      @(posedge clk);
      @(negedge clk);
      drive(1'b0, '0, '0, '0);
      check_state(tags[b]);
    end

    // Directed: known values after the table, per requirement.
    peek_addr_i = 4'd7;  #0.2;
    check(peek_data_o == 32'd20, "R9", "r7 after conflict", peek_data_o, 32'd20);
    peek_addr_i = 4'd8;  #0.2;
    check(peek_data_o == 32'd5, "R7", "r8 old operand", peek_data_o, 32'd5);
    peek_addr_i = 4'd9;  #0.2;
    check(peek_data_o == 32'd6, "R6", "r9 negative imm", peek_data_o, 32'd6);
    peek_addr_i = 4'd10; #0.2;
    check(peek_data_o == 32'hFFFF8000, "R6", "r10 sign extension", peek_data_o, 32'hFFFF8000);
    peek_addr_i = 4'd12; #0.2;
    check(peek_data_o == 32'd3, "R8", "r12 old guard", peek_data_o, 32'd3);
    check(pred_o[0] == 1'b1, "R5", "p0 still set", {31'd0, pred_o[0]}, 32'd1);
    check(pred_o[6] == 1'b0, "R10", "p6 complement kept", {31'd0, pred_o[6]}, 32'd0);
    check(pred_o[7] == 1'b0, "R10", "p7 top slot", {31'd0, pred_o[7]}, 32'd0);

    // Idle cycle: strobes fall back (R11, R12).
    @(posedge clk);
    @(negedge clk);
    model_step(1'b0, '0, '0, '0);
    check_state("R12 idle");

    // Reset in the middle of a run.
    rst_n = 1'b0;
    model_reset();
    #1;
    check_state("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 released");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule